// File: doc/BRIEF.md
# Per-CPU Interrupt Presentation Controller

This block sits between an interrupt source network and a single processor. The source side offers one request at a time as a vector and a priority. Software can also post an inter-processor interrupt (IPI) through a byte-wide request register. The block compares each candidate against the current processor priority. When at least one candidate is favoured strictly more than that priority, it raises the CPU interrupt line. A lower number means a more favoured priority.

Software reaches the block over a 32-bit register bus with byte enables. The registers are big-endian, so byte lane 0 is bits 31:24 and is enabled by `bus_be[3]`. Word 1, at offset 0x4, is the accept register. It packs the processor priority in bits 31:24 and a vector in bits 23:0. Reading it takes the presented request and raises the processor priority to that request's priority. A full-word write to it is the end-of-interrupt: it restores the priority and names the completed vector to the source side. Word 0 is a copy of the accept register that can be read with no side effects. Word 3, at offset 0xC, holds the IPI request priority in its top byte.

Top module: `cpu_irq_presenter`

## Requirements
- R1: After reset the processor priority is 0, the IPI request register is 0xFF, `cpu_irq` is low, and no end-of-interrupt is signalled.
- R2: `cpu_irq` is high in the same cycle, combinationally, exactly when the IPI or a valid external request has a priority numerically lower than the processor priority. Equal priority does not present.
- R3: A read at offset 0x4 returns {processor priority, presented vector} using the priority held before the read. If a request is presented, the processor priority takes that request's priority on the next cycle, which drops `cpu_irq`.
- R4: A read at offset 0x0 returns the same word as R3 and changes no state.
- R5: When nothing is presentable, the vector field of words 0x0 and 0x4 reads as the spurious vector 0.
- R6: A write with `bus_be[3]` set at offset 0xC loads bits 31:24 into the IPI request register. An IPI is presentable with vector 2 when that value is below the processor priority, and 0xFF never presents one.
- R7: Between the IPI and an external request, the numerically lower priority is presented. On equal priority the IPI wins.
- R8: A write at offset 0x4 with `bus_be`=4'b1111 is an end-of-interrupt. The processor priority takes bits 31:24. On the next cycle `eoi_valid` pulses high for one cycle and `eoi_vector` carries bits 23:0.
- R9: A write at offset 0x4 with `bus_be`=4'b1000 loads only the processor priority from bits 31:24 and does not pulse `eoi_valid`.
- R10: Writes at offsets 0x8, 0x10, 0x14 and 0x18 and at unaligned addresses change no state, and reads there return 0. So do writes at 0x4 with any other byte-enable pattern.
- R11: A read at offset 0xC returns the IPI request register in bits 31:24 and zeros below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_be | input | 4 | Byte enables; bit 3 enables bits 31:24 (byte lane 0) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| src_valid | input | 1 | External request present |
| src_vector | input | VEC_W | External request vector |
| src_prio | input | PRIO_W | External request priority |
| cpu_irq | output | 1 | Interrupt line to the processor |
| eoi_valid | output | 1 | One-cycle end-of-interrupt pulse |
| eoi_vector | output | VEC_W | Vector completed by the end-of-interrupt |

## Verification
The processor priority is the state that matters most. A wrong value shows up in the same cycle in two places: `cpu_irq` goes wrong for any request near the threshold, and the top byte of a read of word 0 or word 1 is wrong. A stale IPI register shows at once in the vector field and in the word read at 0xC. A lost or doubled end-of-interrupt is visible one cycle after the write on `eoi_valid`. The reference model is compared with the design on every cycle, so any divergence is caught within one clock of the access that caused it.

// File: rtl/cip_pkg.sv
package cip_pkg;
  localparam int PRIO_W = 8;
  localparam int VEC_W  = 24;
  localparam int WORD_W = PRIO_W + VEC_W;

  typedef logic [PRIO_W-1:0] prio_t;
  typedef logic [VEC_W-1:0]  vec_t;

  localparam prio_t PRIO_NONE    = '1;
  localparam vec_t  VEC_SPURIOUS = '0;
  localparam vec_t  VEC_IPI      = vec_t'(2);

  localparam int WIDX_POLL   = 0;
  localparam int WIDX_ACCEPT = 1;
  localparam int WIDX_IPI    = 3;

  localparam logic [3:0] BE_WORD = 4'b1111;
  localparam logic [3:0] BE_TOP  = 4'b1000;

  // lower number = more favoured
  function automatic logic beats(prio_t cand, prio_t thresh);
    return cand < thresh;
  endfunction

  function automatic logic [WORD_W-1:0] pack_word(prio_t p, vec_t v);
    return {p, v};
  endfunction
endpackage

// File: rtl/cip_arbiter.sv
module cip_arbiter
  import cip_pkg::*;
(
  input  prio_t cppr,
  input  prio_t ipi_prio,
  input  logic  src_valid,
  input  prio_t src_prio,
  input  vec_t  src_vector,
  output logic  pend,
  output logic  ipi_hit,
  output logic  ext_hit,
  output prio_t sel_prio,
  output vec_t  sel_vec
);
  logic take_ipi;

  always_comb begin
    ipi_hit  = (ipi_prio != PRIO_NONE) && beats(ipi_prio, cppr);
    ext_hit  = src_valid && beats(src_prio, cppr);
    take_ipi = ipi_hit && (!ext_hit || !beats(src_prio, ipi_prio));
    pend     = ipi_hit || ext_hit;
    if (take_ipi) begin
      sel_prio = ipi_prio;
      sel_vec  = VEC_IPI;
    end else if (ext_hit) begin
      sel_prio = src_prio;
      sel_vec  = src_vector;
    end else begin
      sel_prio = PRIO_NONE;
      sel_vec  = VEC_SPURIOUS;
    end
  end

  always_comb begin
    // R7
    if (ipi_hit && ext_hit && (ipi_prio == src_prio))
      ipi_tie_wins_chk: assert (sel_vec == VEC_IPI);
    // R2
    if (pend)
      pend_strict_chk: assert (sel_prio < cppr);
  end
endmodule

// File: rtl/cip_regs.sv
module cip_regs
  import cip_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_be,
  input  logic [WORD_W-1:0] bus_wdata,
  input  logic              pend,
  input  prio_t             sel_prio,
  output prio_t             cppr,
  output prio_t             ipi_prio,
  output logic              eoi_valid,
  output vec_t              eoi_vector,
  output logic              accept_evt,
  output logic              eoi_evt
);
  localparam int WIDX_W = ADDR_W - 2;

  logic              aligned;
  logic [WIDX_W-1:0] widx;
  logic              prio_evt;
  logic              ipi_evt;

  always_comb begin
    aligned    = (bus_addr[1:0] == 2'b00);
    widx       = bus_addr[ADDR_W-1:2];
    accept_evt = bus_sel && !bus_we && aligned && (widx == WIDX_W'(WIDX_ACCEPT)) && pend;
    eoi_evt    = bus_sel && bus_we && aligned && (widx == WIDX_W'(WIDX_ACCEPT)) && (bus_be == BE_WORD);
    prio_evt   = bus_sel && bus_we && aligned && (widx == WIDX_W'(WIDX_ACCEPT)) && (bus_be == BE_TOP);
    ipi_evt    = bus_sel && bus_we && aligned && (widx == WIDX_W'(WIDX_IPI)) && bus_be[3];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cppr       <= '0;
      ipi_prio   <= PRIO_NONE;
      eoi_valid  <= 1'b0;
      eoi_vector <= '0;
    end else begin
      eoi_valid <= eoi_evt;
      if (eoi_evt) eoi_vector <= bus_wdata[VEC_W-1:0];
      if (accept_evt)
        cppr <= sel_prio;
      else if (eoi_evt || prio_evt)
        cppr <= bus_wdata[WORD_W-1 -: PRIO_W];
      if (ipi_evt) ipi_prio <= bus_wdata[WORD_W-1 -: PRIO_W];
    end
  end

  // R3
  accept_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> (cppr == $past(sel_prio)));
  // R8
  eoi_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_evt |=> (eoi_valid && eoi_vector == $past(bus_wdata[VEC_W-1:0])));
  // R9
  prio_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prio_evt |=> !eoi_valid);
  // R10
  quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(accept_evt || eoi_evt || prio_evt) |=> $stable(cppr));
endmodule

// File: rtl/cpu_irq_presenter.sv
module cpu_irq_presenter
  import cip_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_be,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic              src_valid,
  input  logic [VEC_W-1:0]  src_vector,
  input  logic [PRIO_W-1:0] src_prio,
  output logic              cpu_irq,
  output logic              eoi_valid,
  output logic [VEC_W-1:0]  eoi_vector
);
  prio_t cppr, ipi_prio, sel_prio;
  vec_t  sel_vec;
  logic  pend, ipi_hit, ext_hit, accept_evt, eoi_evt;

  cip_arbiter u_arb (
    .cppr(cppr), .ipi_prio(ipi_prio), .src_valid(src_valid),
    .src_prio(src_prio), .src_vector(src_vector), .pend(pend),
    .ipi_hit(ipi_hit), .ext_hit(ext_hit), .sel_prio(sel_prio), .sel_vec(sel_vec)
  );

  cip_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .pend(pend), .sel_prio(sel_prio), .cppr(cppr), .ipi_prio(ipi_prio),
    .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
    .accept_evt(accept_evt), .eoi_evt(eoi_evt)
  );

  localparam int WIDX_W = ADDR_W - 2;
  logic [WIDX_W-1:0] ridx;

  always_comb begin
    cpu_irq   = pend;
    ridx      = bus_addr[ADDR_W-1:2];
    bus_rdata = '0;
    if (bus_addr[1:0] == 2'b00) begin
      if (ridx == WIDX_W'(WIDX_POLL) || ridx == WIDX_W'(WIDX_ACCEPT))
        bus_rdata = pack_word(cppr, sel_vec);
      else if (ridx == WIDX_W'(WIDX_IPI))
        bus_rdata = pack_word(ipi_prio, '0);
    end
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |=> (cppr == '0 && ipi_prio == PRIO_NONE && !eoi_valid));
  // R6
  ipi_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ipi_prio == PRIO_NONE) |-> !ipi_hit);
  // R3
  accept_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_evt && !eoi_evt && !(ipi_hit && ext_hit)) |=> (!cpu_irq || $changed(src_prio) || $changed(src_valid) || $changed(ipi_prio)));
endmodule

// File: tb/cpu_irq_presenter_tb_top.sv
module cpu_irq_presenter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        src_valid = 1'b0;
  logic [23:0] src_vector = '0;
  logic [7:0]  src_prio = '0;
  logic        cpu_irq, eoi_valid;
  logic [23:0] eoi_vector;

  always #2.5 clk = ~clk;

  cpu_irq_presenter dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .src_valid(src_valid), .src_vector(src_vector),
    .src_prio(src_prio), .cpu_irq(cpu_irq), .eoi_valid(eoi_valid),
    .eoi_vector(eoi_vector)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int m_cppr, m_ipi, m_eoi_v, m_eoi_vec;

  task automatic check(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // model: pick winner; returns presented flag, prio and vector
  function automatic void model_pick(output bit p, output int pr, output int v);
    bit i_ok = (m_ipi != 255) && (m_ipi < m_cppr);
    bit e_ok = src_valid && (int'(src_prio) < m_cppr);
    p = i_ok || e_ok; pr = 255; v = 0;
    if (e_ok) begin pr = src_prio; v = src_vector; end
    if (i_ok && (!e_ok || m_ipi <= int'(src_prio))) begin pr = m_ipi; v = 2; end
  endfunction

  task automatic cyc(string req, bit sel, bit we, int addr, logic [3:0] be, logic [31:0] wd);
    bit p; int pr, v; int word; longint exp_rd;
    @(negedge clk);
    bus_sel = sel; bus_we = we; bus_addr = addr[4:0]; bus_be = be; bus_wdata = wd;
    #1;
    model_pick(p, pr, v);
    check({req, " irq"}, cpu_irq, p);
    word = addr / 4;
    exp_rd = 0;
    if (addr % 4 == 0) begin
      if (word == 0 || word == 1) exp_rd = (longint'(m_cppr) << 24) | v;
      else if (word == 3) exp_rd = longint'(m_ipi) << 24;
    end
    if (sel && !we) check({req, " rdata"}, bus_rdata, exp_rd);
    m_eoi_v = 0;
    if (sel && (addr % 4 == 0)) begin
      if (!we && word == 1 && p) m_cppr = pr;
      if (we && word == 1 && be == 4'hF) begin
        m_cppr = wd[31:24]; m_eoi_v = 1; m_eoi_vec = wd[23:0];
      end
      if (we && word == 1 && be == 4'h8) m_cppr = wd[31:24];
      if (we && word == 3 && be[3]) m_ipi = wd[31:24];
    end
    @(posedge clk); #1;
    check({req, " eoi_valid"}, eoi_valid, m_eoi_v);
    if (m_eoi_v) check({req, " eoi_vector"}, eoi_vector, m_eoi_vec);
    bus_sel = 0;
  endtask

  task automatic src(bit vld, int pr, int vec);
    src_valid = vld; src_prio = pr[7:0]; src_vector = vec[23:0];
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    m_cppr = 0; m_ipi = 255; m_eoi_v = 0; m_eoi_vec = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1 reset state
    cyc("R1", 1, 0, 4, 4'h0, 0);
    cyc("R1", 1, 0, 12, 4'h0, 0);
    src(1, 5, 24'h1234);
    cyc("R1 blocked at prio 0", 0, 0, 0, 0, 0);
    // R9 priority byte write
    cyc("R9", 1, 1, 4, 4'h8, 32'hFF00_0000);
    // R2 R4 presentation and poll
    cyc("R2", 0, 0, 0, 0, 0);
    cyc("R4", 1, 0, 0, 0, 0);
    cyc("R4", 1, 0, 0, 0, 0);
    // R3 accept
    cyc("R3", 1, 0, 4, 0, 0);
    cyc("R3 R5 after accept", 1, 0, 4, 0, 0);
    // R8 EOI
    cyc("R8", 1, 1, 4, 4'hF, 32'hFF00_1234);
    cyc("R8 represent", 1, 0, 0, 0, 0);
    // R6 R7 IPI tie
    cyc("R6", 1, 1, 12, 4'h8, 32'h0500_0000);
    cyc("R11", 1, 0, 12, 0, 0);
    cyc("R7 tie", 1, 0, 4, 0, 0);
    cyc("R6 cancel", 1, 1, 12, 4'h8, 32'hFF00_0000);
    cyc("R8 ipi eoi", 1, 1, 4, 4'hF, 32'hFF00_0002);
    cyc("R6 ext again", 1, 0, 0, 0, 0);
    cyc("R7", 1, 1, 12, 4'h8, 32'h0300_0000);
    cyc("R7 ipi better", 1, 0, 0, 0, 0);
    cyc("R7", 1, 1, 12, 4'h8, 32'h0700_0000);
    cyc("R7 ext better", 1, 0, 0, 0, 0);
    cyc("R6", 1, 1, 12, 4'hF, 32'hFFAB_CDEF);
    // R2 strict
    cyc("R2", 1, 1, 4, 4'h8, 32'h0500_0000);
    cyc("R2 equal", 1, 0, 0, 0, 0);
    src(1, 4, 24'h77);
    cyc("R2 lower", 1, 0, 0, 0, 0);
    src(0, 1, 24'h55);
    cyc("R5", 1, 0, 4, 0, 0);
    // R10 ignored accesses
    cyc("R10", 1, 1, 8, 4'hF, 32'h0000_0000);
    cyc("R10", 1, 1, 16, 4'hF, 32'h0000_0000);
    cyc("R10", 1, 1, 24, 4'hF, 32'h0000_0000);
    cyc("R10", 1, 1, 4, 4'h3, 32'h0000_0000);
    cyc("R10", 1, 1, 5, 4'hF, 32'h0000_0000);
    cyc("R10", 1, 1, 13, 4'h8, 32'h0000_0000);
    cyc("R10", 1, 0, 20, 0, 0);
    cyc("R10", 1, 0, 6, 0, 0);
    cyc("R10 state", 1, 0, 4, 0, 0);
    cyc("R10 state", 1, 0, 12, 0, 0);
    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      int a; logic [3:0] be; logic [31:0] wd;
      src($urandom_range(0, 1), $urandom_range(0, 15), $urandom_range(3, 40));
      a = 4 * $urandom_range(0, 6);
      be = ($urandom_range(0, 1) != 0) ? 4'hF : 4'h8;
      wd = {$urandom_range(0, 1) != 0 ? 8'hFF : 8'($urandom_range(0, 16)), 24'($urandom_range(0, 40))};
      cyc("R2 R3 R7 R8 mixed", $urandom_range(0, 3) != 0, $urandom_range(0, 1) != 0, a, be, wd);
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule